// File: doc/BRIEF.md
# Dual-Mode Serial Command Receiver for a Multi-Channel DAC

This block is the slave end of a three-wire serial link that feeds a multi-channel DAC controller. A host drives a serial clock, an active-low frame enable and a data line. The block assembles 24-bit command words, MSB first, and hands each accepted word to the downstream decoder with a one-cycle strobe. An active-low hold flag tells the host that an update is in progress. All serial pins are asynchronous to the block's system clock. Each pin passes through a multi-flop synchronizer, and its edges are detected in the system domain.

There are two framing modes. In standalone mode a word is accepted as soon as its 24th bit has been sampled. In daisy-chain mode every bit also leaves on a chain output, 24 serial clocks after it arrived, so that devices can be cascaded. In this mode the word is accepted only when the frame closes. Three more active-low inputs control what happens around a word: a load input (immediate or deferred output update), a clear input, and a soft reset that runs a timed reset sequence.

The controller is a three-state machine. In IDLE the hold flag is high. It leaves for BUSY on "word available" and for RESET on "soft reset edge". It returns from BUSY to IDLE on "busy timer expired" and from RESET to IDLE on "reset timer expired". A soft reset edge forces RESET from any state.

Top module: `serdac_rx`

## Requirements
- R1: Serial bits are sampled on falling edges of `ser_clk_i` while `frame_n_i` is low, first bit is bit 23 (MSB first); an accepted word appears on `cmd_o` together with a one-cycle `cmd_vld_o` pulse.
- R2: With `chain_en_i` = 0 (standalone) a word is accepted after its 24th falling edge without waiting for `frame_n_i` to rise; further bits in the same frame are ignored.
- R3: In standalone mode a frame closed before 24 bits have arrived produces no strobe.
- R4: With `chain_en_i` = 1, `chain_dat_o` changes on rising edges of `ser_clk_i` and shows the bit sampled 24 falling edges earlier.
- R5: In daisy-chain mode the word is accepted when `frame_n_i` rises, holding the last 24 bits received, only if the bit count is a non-zero multiple of 24; any other frame is dropped.
- R6: `hold_n_o` goes low in the cycle of `cmd_vld_o` and stays low for exactly BUSY_CYCLES system clock cycles.
- R7: A frame that completes while `hold_n_o` is low is kept, and its strobe appears only after `hold_n_o` has been high for at least one cycle.
- R8: A falling edge on `load_n_i` during BUSY gives one `apply_o` pulse in the first cycle that `hold_n_o` is high again; if `load_n_i` stays high throughout, no pulse follows the busy period.
- R9: A falling edge on `load_n_i` in IDLE gives one `apply_o` pulse within three cycles; if `load_n_i` is held low, a pulse follows at the end of each busy period.
- R10: A falling edge on `clear_n_i` gives one `zero_o` pulse.
- R11: A falling edge on `soft_rst_n_i` holds `hold_n_o` low for exactly RESET_CYCLES cycles, discards any word that is waiting or partly shifted, and gives a `zero_o` pulse when the sequence completes.
- R12: After system reset `hold_n_o` is high and `cmd_vld_o`, `apply_o`, `zero_o` and `chain_dat_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| frame_n_i | input | 1 | Active-low frame enable |
| ser_dat_i | input | 1 | Serial data, MSB first |
| chain_en_i | input | 1 | 1 = daisy-chain framing, 0 = standalone |
| load_n_i | input | 1 | Active-low output-update request |
| clear_n_i | input | 1 | Active-low clear request |
| soft_rst_n_i | input | 1 | Active-low reset-sequence request |
| cmd_o | output | 24 | Last accepted command word |
| cmd_vld_o | output | 1 | One-cycle strobe for a new command word |
| chain_dat_o | output | 1 | Daisy-chain serial output |
| hold_n_o | output | 1 | Low while an update or reset sequence runs |
| apply_o | output | 1 | One-cycle output-update pulse |
| zero_o | output | 1 | One-cycle clear pulse |

## Verification
A bit counter that slips by one shows up at the ports within a frame. A standalone strobe then arrives a bit early or late, carrying a shifted word. A daisy-chain frame that should be accepted is dropped, or the reverse. A wrong chain-register tap shows on `chain_dat_o` from the 25th serial clock onward. A stuck or mis-loaded timer is visible as a low period of `hold_n_o` that differs from the parameter. A lost latch of the load request shows as a missing `apply_o` pulse at the end of the busy period. Each of these is caught no later than the first frame or busy period that uses the faulty state.

// File: rtl/serdac_rx_pkg.sv
package serdac_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_RESET = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/serdac_rx_sync.sv
module serdac_rx_sync #(
    parameter int              WIDTH  = 1,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe;

        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= {STAGES{INIT[g]}};
                else        pipe <= {pipe[STAGES-2:0], raw_i[g]};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= INIT[g];
                else        pipe <= raw_i[g];
            end
        end

        assign lvl_o[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/serdac_rx_shift.sv
module serdac_rx_shift #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_en,
    input  logic              sclk_lvl,
    input  logic              frame_lvl,
    input  logic              bit_in,
    input  logic              flush,
    output logic [WORD_W-1:0] word_o,
    output logic              req_o,
    output logic              chain_o
);

    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic              sclk_q;
    logic              frame_q;
    logic [WORD_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic              filled;
    logic              full_seen;

    logic sclk_fall, sclk_rise, frame_fall, frame_rise, take_bit;

    assign sclk_fall  = sclk_q & ~sclk_lvl;
    assign sclk_rise  = ~sclk_q & sclk_lvl;
    assign frame_fall = frame_q & ~frame_lvl;
    assign frame_rise = ~frame_q & frame_lvl;
    assign take_bit   = ~frame_lvl & sclk_fall & ~full_seen;

    // Edge history of the synchronized serial clock and frame enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            frame_q <= 1'b1;
        end else begin
            sclk_q  <= sclk_lvl;
            frame_q <= frame_lvl;
        end
    end

    // Shift register, bit counter and commit decision for both modes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            cnt       <= '0;
            filled    <= 1'b0;
            full_seen <= 1'b0;
            req_o     <= 1'b0;
            word_o    <= '0;
            chain_o   <= 1'b0;
        end else if (flush) begin
            cnt       <= '0;
            filled    <= 1'b0;
            full_seen <= 1'b0;
            req_o     <= 1'b0;
            chain_o   <= 1'b0;
        end else begin
            req_o <= 1'b0;
            if (frame_fall) begin
                cnt       <= '0;
                filled    <= 1'b0;
                full_seen <= 1'b0;
            end else if (take_bit) begin
                sh <= {sh[WORD_W-2:0], bit_in};
                if (cnt == LAST) begin
                    cnt    <= '0;
                    filled <= 1'b1;
                    if (!chain_en) begin
                        req_o     <= 1'b1;
                        full_seen <= 1'b1;
                        word_o    <= {sh[WORD_W-2:0], bit_in};
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else if (frame_rise && chain_en && filled && (cnt == '0)) begin
                req_o  <= 1'b1;
                word_o <= sh;
            end
            if (sclk_rise && chain_en) chain_o <= sh[WORD_W-1];
        end
    end

    AST_CHAIN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chain_o) |-> ($past(sclk_rise) || $past(flush))); // R4

    AST_SA_COMMIT_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !$past(chain_en)) |-> $past(sclk_fall)); // R2

    AST_DC_COMMIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(chain_en)) |-> $past(frame_rise)); // R5

endmodule

// File: rtl/serdac_rx_ctrl.sv
module serdac_rx_ctrl
    import serdac_rx_pkg::*;
#(
    parameter int WORD_W       = 24,
    parameter int BUSY_CYCLES  = 33,
    parameter int RESET_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] word_in,
    input  logic              load_lvl,
    input  logic              clear_lvl,
    input  logic              srst_lvl,
    output logic [WORD_W-1:0] cmd_o,
    output logic              cmd_vld_o,
    output logic              hold_n_o,
    output logic              apply_o,
    output logic              zero_o,
    output logic              in_reset_o
);

    localparam int MAXC = (BUSY_CYCLES > RESET_CYCLES) ? BUSY_CYCLES : RESET_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] BUSY_LOAD  = TW'(BUSY_CYCLES - 1);
    localparam logic [TW-1:0] RESET_LOAD = TW'(RESET_CYCLES - 1);

    ctl_state_e        state, nxt;
    logic [TW-1:0]     timer;
    logic              pend_vld;
    logic [WORD_W-1:0] pend_word;
    logic              load_seen;
    logic              load_q, clear_q, srst_q;

    logic load_fall, clear_fall, srst_fall, avail, timer_zero;

    assign load_fall  = load_q & ~load_lvl;
    assign clear_fall = clear_q & ~clear_lvl;
    assign srst_fall  = srst_q & ~srst_lvl;
    assign avail      = pend_vld | req;
    assign timer_zero = (timer == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= 1'b1;
            clear_q <= 1'b1;
            srst_q  <= 1'b1;
        end else begin
            load_q  <= load_lvl;
            clear_q <= clear_lvl;
            srst_q  <= srst_lvl;
        end
    end

    // Next-state decision.
    always_comb begin
        nxt = state;
        if (srst_fall) begin
            nxt = ST_RESET;
        end else begin
            unique case (state)
                ST_IDLE:  if (avail)      nxt = ST_BUSY;
                ST_BUSY:  if (timer_zero) nxt = ST_IDLE;
                ST_RESET: if (timer_zero) nxt = ST_IDLE;
                default:                  nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Outputs, timer and waiting word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer     <= '0;
            pend_vld  <= 1'b0;
            pend_word <= '0;
            load_seen <= 1'b0;
            cmd_o     <= '0;
            cmd_vld_o <= 1'b0;
            apply_o   <= 1'b0;
            zero_o    <= 1'b0;
        end else begin
            cmd_vld_o <= 1'b0;
            apply_o   <= 1'b0;
            zero_o    <= 1'b0;
            if (!timer_zero) timer <= timer - TW'(1);
            if (clear_fall && state != ST_RESET) zero_o <= 1'b1;
            if (srst_fall) begin
                timer     <= RESET_LOAD;
                pend_vld  <= 1'b0;
                load_seen <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (avail) begin
                            timer     <= BUSY_LOAD;
                            cmd_o     <= req ? word_in : pend_word;
                            cmd_vld_o <= 1'b1;
                            pend_vld  <= 1'b0;
                            load_seen <= 1'b0;
                        end
                        if (load_fall) apply_o <= 1'b1;
                    end
                    ST_BUSY: begin
                        if (req) begin
                            pend_vld  <= 1'b1;
                            pend_word <= word_in;
                        end
                        if (load_fall) load_seen <= 1'b1;
                        if (timer_zero && (load_seen || load_fall || !load_lvl))
                            apply_o <= 1'b1;
                    end
                    ST_RESET: begin
                        pend_vld <= 1'b0;
                        if (timer_zero) zero_o <= 1'b1;
                    end
                    default: pend_vld <= 1'b0;
                endcase
            end
        end
    end

    assign hold_n_o   = (state == ST_IDLE);
    assign in_reset_o = (state == ST_RESET);

    AST_STROBE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> ($past(state) == ST_IDLE)); // R7

    AST_STROBE_OPENS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> !hold_n_o); // R6

    AST_APPLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |-> hold_n_o); // R8

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |-> !cmd_vld_o); // R11

    AST_BUSY_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && timer_zero && !srst_fall) |=> hold_n_o); // R6

endmodule

// File: rtl/serdac_rx.sv
module serdac_rx #(
    parameter int WORD_W       = 24,
    parameter int SYNC_STAGES  = 2,
    parameter int BUSY_CYCLES  = 33,
    parameter int RESET_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              frame_n_i,
    input  logic              ser_dat_i,
    input  logic              chain_en_i,
    input  logic              load_n_i,
    input  logic              clear_n_i,
    input  logic              soft_rst_n_i,
    output logic [WORD_W-1:0] cmd_o,
    output logic              cmd_vld_o,
    output logic              chain_dat_o,
    output logic              hold_n_o,
    output logic              apply_o,
    output logic              zero_o
);

    localparam int NPIN = 7;
    localparam logic [NPIN-1:0] PIN_INIT = 7'b0111010;

    logic [NPIN-1:0]   pin_lvl;
    logic [WORD_W-1:0] shift_word;
    logic              shift_req;
    logic              in_reset;

    serdac_rx_sync #(
        .WIDTH  (NPIN),
        .STAGES (SYNC_STAGES),
        .INIT   (PIN_INIT)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({chain_en_i, soft_rst_n_i, clear_n_i, load_n_i,
                 ser_dat_i, frame_n_i, ser_clk_i}),
        .lvl_o (pin_lvl)
    );

    serdac_rx_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .chain_en  (pin_lvl[6]),
        .sclk_lvl  (pin_lvl[0]),
        .frame_lvl (pin_lvl[1]),
        .bit_in    (pin_lvl[2]),
        .flush     (in_reset),
        .word_o    (shift_word),
        .req_o     (shift_req),
        .chain_o   (chain_dat_o)
    );

    serdac_rx_ctrl #(
        .WORD_W       (WORD_W),
        .BUSY_CYCLES  (BUSY_CYCLES),
        .RESET_CYCLES (RESET_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (shift_req),
        .word_in    (shift_word),
        .load_lvl   (pin_lvl[3]),
        .clear_lvl  (pin_lvl[4]),
        .srst_lvl   (pin_lvl[5]),
        .cmd_o      (cmd_o),
        .cmd_vld_o  (cmd_vld_o),
        .hold_n_o   (hold_n_o),
        .apply_o    (apply_o),
        .zero_o     (zero_o),
        .in_reset_o (in_reset)
    );

endmodule

// File: tb/serdac_rx_bench.sv
module serdac_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int BSY        = 300;
    localparam int RST        = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk_i = 1'b0, frame_n_i = 1'b1, ser_dat_i = 1'b0;
    logic        chain_en_i = 1'b0, load_n_i = 1'b1, clear_n_i = 1'b1, soft_rst_n_i = 1'b1;
    logic [23:0] cmd_o;
    logic        cmd_vld_o, chain_dat_o, hold_n_o, apply_o, zero_o;

    int n_checks = 0, n_err = 0;
    int n_vld = 0, n_apply = 0, n_apply_rise = 0, n_zero = 0;
    int low_run = 0;
    logic prev_hold = 1'b1;
    logic rst_phase = 1'b0;
    logic [23:0] exp_q[$];

    serdac_rx #(.WORD_W(24), .SYNC_STAGES(2), .BUSY_CYCLES(BSY), .RESET_CYCLES(RST)) u_serdac_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .frame_n_i(frame_n_i),
        .ser_dat_i(ser_dat_i), .chain_en_i(chain_en_i), .load_n_i(load_n_i),
        .clear_n_i(clear_n_i), .soft_rst_n_i(soft_rst_n_i), .cmd_o(cmd_o),
        .cmd_vld_o(cmd_vld_o), .chain_dat_o(chain_dat_o), .hold_n_o(hold_n_o),
        .apply_o(apply_o), .zero_o(zero_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected words and tracks pulses and hold periods.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_vld_o) begin
                n_vld++;
                if (exp_q.size() == 0) begin
                    check("R3 R5 unexpected strobe", int'(cmd_o), -1);
                end else begin
                    check("R1 word", int'(cmd_o), int'(exp_q.pop_front()));
                    check("R7 strobe after idle", int'(prev_hold), 1);
                end
            end
            if (apply_o) begin
                n_apply++;
                if (!prev_hold) n_apply_rise++;
                check("R8 apply while idle", int'(hold_n_o), 1);
            end
            if (zero_o) n_zero++;
            if (!hold_n_o) low_run++;
            else if (low_run != 0) begin
                if (rst_phase) check("R11 reset length", low_run, RST);
                else           check("R6 busy length", low_run, BSY);
                low_run = 0;
            end
            prev_hold = hold_n_o;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input int n, input logic [47:0] val, input logic chk_chain);
        frame_n_i = 1'b0;
        wait_clk(HALF);
        for (int k = 1; k <= n; k++) begin
            ser_clk_i = 1'b1;
            ser_dat_i = val[n-k];
            wait_clk(HALF);
            if (chk_chain && k > 24) check("R4 chain bit", int'(chain_dat_o), int'(val[n-k+24]));
            ser_clk_i = 1'b0;
            wait_clk(HALF);
        end
    endtask

    task automatic end_frame();
        frame_n_i = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic pulse_load();
        load_n_i = 1'b0; wait_clk(HALF); load_n_i = 1'b1; wait_clk(HALF);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int base_vld, base_apply, base_rise, base_zero;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R12 reset state
        check("R12 hold_n", int'(hold_n_o), 1);
        check("R12 cmd_vld", int'(cmd_vld_o), 0);
        check("R12 apply", int'(apply_o), 0);
        check("R12 zero", int'(zero_o), 0);
        check("R12 chain", int'(chain_dat_o), 0);

        // R2: standalone commit before release, extra bits ignored
        exp_q.push_back(24'hA53C96);
        base_apply = n_apply;
        send_bits(24, {24'h0, 24'hA53C96}, 1'b0);
        wait_clk(HALF);
        check("R2 strobe before frame release", n_vld, 1);
        send_bits(5, 48'h1F, 1'b0);
        end_frame();
        wait_clk(BSY + 20);
        check("R8 no apply without load", n_apply, base_apply);

        // R9: load edge while idle
        pulse_load();
        wait_clk(4);
        check("R9 idle apply", n_apply, base_apply + 1);

        // R3: short standalone frame dropped
        base_vld = n_vld;
        send_bits(10, 48'h2AB, 1'b0);
        end_frame();
        wait_clk(50);
        check("R3 partial dropped", n_vld, base_vld);

        // R7 / R8: second frame during busy, load edge during busy
        base_apply = n_apply;
        base_rise  = n_apply_rise;
        exp_q.push_back(24'h123456);
        exp_q.push_back(24'hFEDCBA);
        send_bits(24, {24'h0, 24'h123456}, 1'b0);
        end_frame();
        pulse_load();
        send_bits(24, {24'h0, 24'hFEDCBA}, 1'b0);
        end_frame();
        check("R7 second word held while busy", n_vld, base_vld + 1);
        wait_clk(2 * BSY + 50);
        check("R7 second word accepted", n_vld, base_vld + 2);
        check("R8 apply at busy end", n_apply_rise, base_rise + 1);
        check("R8 single apply", n_apply, base_apply + 1);

        // R4 / R5: daisy chain, two words in one frame
        chain_en_i = 1'b1;
        wait_clk(8);
        exp_q.push_back(24'h5A0FF0);
        send_bits(48, {24'hC3A55A, 24'h5A0FF0}, 1'b1);
        check("R5 no strobe before release", n_vld, base_vld + 2);
        end_frame();
        wait_clk(BSY + 20);
        check("R5 chain word accepted", n_vld, base_vld + 3);

        // R5: 30-bit chain frame dropped
        send_bits(30, 48'h3ABCDEF1, 1'b0);
        end_frame();
        wait_clk(50);
        check("R5 non-multiple dropped", n_vld, base_vld + 3);

        // R9: load held low through busy
        base_apply = n_apply;
        base_rise  = n_apply_rise;
        load_n_i = 1'b0;
        wait_clk(8);
        exp_q.push_back(24'h0F1E2D);
        send_bits(24, {24'h0, 24'h0F1E2D}, 1'b0);
        end_frame();
        wait_clk(BSY + 20);
        check("R9 held load applies at busy end", n_apply_rise, base_rise + 1);
        check("R9 held load total", n_apply, base_apply + 2);
        load_n_i = 1'b1;
        wait_clk(8);

        // R10: clear
        base_zero = n_zero;
        clear_n_i = 1'b0; wait_clk(HALF); clear_n_i = 1'b1;
        wait_clk(8);
        check("R10 clear pulse", n_zero, base_zero + 1);

        // R11: reset sequence discards a half-shifted frame
        rst_phase = 1'b1;
        chain_en_i = 1'b0;
        wait_clk(8);
        send_bits(12, 48'hABC, 1'b0);
        soft_rst_n_i = 1'b0; wait_clk(HALF); soft_rst_n_i = 1'b1;
        send_bits(12, 48'hDEF, 1'b0);
        end_frame();
        wait_clk(RST + 30);
        check("R11 zero at reset end", n_zero, base_zero + 2);
        check("R11 no strobe from reset", n_vld, base_vld + 4);
        rst_phase = 1'b0;

        check("R5 queue drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule